// File: doc/BRIEF.md
# Stereo Multi-Format Audio Serial Port

This block moves stereo 24-bit audio samples between a serial audio link and a parallel interface inside the chip. A bit clock and a word clock arrive from outside. Both are oversampled on the system clock, and their edges are found by comparing each sample with the one before. On the transmit side a pair of parallel sample words is shifted out MSB first on the serial output line. On the receive side a pair of words is assembled from the serial input line. Samples are 24-bit two's complement values.

A two-bit format selector picks one of three framings. In left-justified framing the word clock is high for the left channel and the MSB sits in the first bit slot of each half frame. In I2S framing the word clock is low for the left channel and the MSB is one bit slot late. The mixed framing transmits left-justified but receives right-justified inside a 32-slot half frame. Any word-clock edge restarts the bit position, whatever the bit count, so half frames shorter than 32 slots work as well.

The transmit words are captured when a left half frame starts, so the shift stays coherent if the words change mid-frame. A received stereo pair is presented with a single-cycle valid pulse after the right-channel LSB has been sampled. A power-down input silences the output line and suspends the framing state.

Top module: `audio_serial_port`

## Requirements
- R1: With format code 0 (left-justified) or 2 (mixed), bit slot p (p = 0 for the first slot of a half frame) carries word bit 23-p of that channel's transmit word for p = 0..23. Slots from 24 on drive 0.
- R2: Format codes 0 and 2 treat word clock high as the left channel. Format code 1 (I2S) treats word clock low as the left channel. The right channel takes the other level.
- R3: With format code 1, slot p carries and receives word bit 24-p for p = 1..24. On transmit, slot 0 and slots from 25 on drive 0. On receive, those slots are ignored.
- R4: With format code 0, receive slot p supplies word bit 23-p for p = 0..23. Input in later slots of the half frame has no effect on the received word.
- R5: With format code 2, receive slot p supplies word bit 31-p for p = 8..31. Input in slots 0..7 has no effect on the received word.
- R6: The serial output changes only after a detected falling bit-clock edge, or when power-down is applied. It stays steady across rising edges. Input is sampled at rising edges.
- R7: While power-down is high, the serial output is 0 and no valid pulse is produced. After power-down is released, normal framing resumes.
- R8: After the right-channel LSB is sampled, the received left and right words update together and `rxValid` pulses high for exactly one cycle. Outside that pulse the received words hold their values.
- R9: Both transmit words are latched at the first falling bit-clock edge of a left half frame. Changing `txLeft` or `txRight` later in the frame does not alter the bits being sent.
- R10: Every word-clock transition seen at a falling bit-clock edge restarts the slot position at 0. A half frame of 24 bit clocks (48 per frame) therefore carries and receives full words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrDn | input | 1 | Power-down: silences output and clears framing state |
| fmtSel | input | 2 | Framing: 0 left-justified, 1 I2S, 2 mixed (left-justified out, right-justified in) |
| bitClk | input | 1 | Serial bit clock |
| wordClk | input | 1 | Serial word (channel) clock |
| serIn | input | 1 | Serial receive data |
| serOut | output | 1 | Serial transmit data |
| txLeft | input | 24 | Left transmit sample |
| txRight | input | 24 | Right transmit sample |
| rxLeft | output | 24 | Last received left sample |
| rxRight | output | 24 | Last received right sample |
| rxValid | output | 1 | One-cycle pulse when a new stereo pair is presented |

## Verification
The assertions check on every cycle that the output moves only after a detected falling edge or under power-down. They also check that power-down keeps the output and the valid strobe low, that the valid strobe never lasts more than one cycle, that the received words hold outside it, and that a word-clock transition resets the slot position. Only the directed scenarios can show that the bit order and the slot windows are right in each format. The same holds for the left/right polarity, for input in ignored slots leaving the received words unchanged, for mid-frame changes to the transmit words being harmless, and for the 48-clock frame.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 32;
  localparam int POS_W    = $clog2(SLOT_W) + 1;
  localparam int IDX_W    = $clog2(SAMPLE_W);

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_MIX = 2'd2
  } fmt_e;

  typedef struct packed {
    logic             fallEdge;
    logic             riseEdge;
    logic             halfStart;
    logic             frameStart;
    logic             txLeft;
    logic             txActive;
    logic [IDX_W-1:0] txIdx;
    logic             rxActive;
    logic             rxLast;
    logic             rxLeft;
    logic             rxBit;
    logic [POS_W-1:0] pos;
  } strb_t;
endpackage

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrDn,
  input  logic [1:0] fmtSel,
  input  logic       bitClk,
  input  logic       wordClk,
  input  logic       serIn,
  output strb_t      strb
);
  localparam logic [POS_W-1:0] POS_MAX  = '1;
  localparam logic [POS_W-1:0] SAMPLE_P = POS_W'(SAMPLE_W);
  localparam logic [POS_W-1:0] RJ_OFF   = POS_W'(SLOT_W - SAMPLE_W);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(SAMPLE_W - 1);

  logic sclkQ, sclkD, wclkQ, sdQ;
  logic wclkPrev, chanLeft;
  logic [POS_W-1:0] posCnt, posNext, txStartPos, rxStartPos, txRel;
  logic leftLvl, fall, rise, halfStartC, chanNext;
  fmt_e fmt;

  // input sampling and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkQ <= 1'b0;
      sclkD <= 1'b0;
      wclkQ <= 1'b0;
      sdQ   <= 1'b0;
    end else begin
      sclkQ <= bitClk;
      sclkD <= sclkQ;
      wclkQ <= wordClk;
      sdQ   <= serIn;
    end
  end

  always_comb begin
    fmt  = fmt_e'(fmtSel);
    fall = sclkD & ~sclkQ;
    rise = ~sclkD & sclkQ;
    case (fmt)
      FMT_I2S: begin leftLvl = 1'b0; txStartPos = POS_W'(1); rxStartPos = POS_W'(1); end
      FMT_MIX: begin leftLvl = 1'b1; txStartPos = '0;        rxStartPos = RJ_OFF;    end
      default: begin leftLvl = 1'b1; txStartPos = '0;        rxStartPos = '0;        end
    endcase
    halfStartC = fall && (wclkQ != wclkPrev);
    if (halfStartC)            posNext = '0;
    else if (posCnt == POS_MAX) posNext = posCnt;
    else                        posNext = posCnt + POS_W'(1);
    chanNext = halfStartC ? (wclkQ == leftLvl) : chanLeft;
    txRel    = posNext - txStartPos;
  end

  // slot position and channel, advanced at falling bit-clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclkPrev <= 1'b0;
      posCnt   <= POS_MAX;
      chanLeft <= 1'b0;
    end else if (pwrDn) begin
      wclkPrev <= 1'b0;
      posCnt   <= POS_MAX;
      chanLeft <= 1'b0;
    end else if (fall) begin
      wclkPrev <= wclkQ;
      posCnt   <= posNext;
      chanLeft <= chanNext;
    end
  end

  always_comb begin
    strb.fallEdge   = fall;
    strb.riseEdge   = rise;
    strb.halfStart  = halfStartC;
    strb.frameStart = halfStartC && (wclkQ == leftLvl);
    strb.txLeft     = chanNext;
    strb.txActive   = (posNext >= txStartPos) && (posNext < txStartPos + SAMPLE_P);
    strb.txIdx      = TOP_IDX - txRel[IDX_W-1:0];
    strb.rxActive   = (posCnt >= rxStartPos) && (posCnt < rxStartPos + SAMPLE_P);
    strb.rxLast     = (posCnt == rxStartPos + SAMPLE_P - POS_W'(1));
    strb.rxLeft     = chanLeft;
    strb.rxBit      = sdQ;
    strb.pos        = posCnt;
  end
endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwrDn,
  input  strb_t               strb,
  input  logic [SAMPLE_W-1:0] txLeftIn,
  input  logic [SAMPLE_W-1:0] txRightIn,
  output logic                serOut,
  output logic [SAMPLE_W-1:0] rxLeftOut,
  output logic [SAMPLE_W-1:0] rxRightOut,
  output logic                rxValid
);
  logic [SAMPLE_W-1:0] txLReg, txRReg, txWord;
  logic [SAMPLE_W-1:0] rxShift, rxPend, rxFull;

  always_comb begin
    if (strb.txLeft) txWord = strb.frameStart ? txLeftIn : txLReg;
    else             txWord = txRReg;
    rxFull = {rxShift[SAMPLE_W-2:0], strb.rxBit};
  end

  // transmit: latch at frame start, drive on falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txLReg <= '0;
      txRReg <= '0;
      serOut <= 1'b0;
    end else if (pwrDn) begin
      serOut <= 1'b0;
    end else if (strb.fallEdge) begin
      if (strb.frameStart) begin
        txLReg <= txLeftIn;
        txRReg <= txRightIn;
      end
      serOut <= strb.txActive ? txWord[strb.txIdx] : 1'b0;
    end
  end

  // receive: sample on rising edges inside the window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift    <= '0;
      rxPend     <= '0;
      rxLeftOut  <= '0;
      rxRightOut <= '0;
      rxValid    <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (!pwrDn && strb.riseEdge && strb.rxActive) begin
        rxShift <= rxFull;
        if (strb.rxLast) begin
          if (strb.rxLeft) begin
            rxPend <= rxFull;
          end else begin
            rxLeftOut  <= rxPend;
            rxRightOut <= rxFull;
            rxValid    <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwrDn,
  input  logic [1:0]          fmtSel,
  input  logic                bitClk,
  input  logic                wordClk,
  input  logic                serIn,
  output logic                serOut,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);
  strb_t strb;

  asp_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwrDn  (pwrDn),
    .fmtSel (fmtSel),
    .bitClk (bitClk),
    .wordClk(wordClk),
    .serIn  (serIn),
    .strb   (strb)
  );

  asp_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrDn     (pwrDn),
    .strb      (strb),
    .txLeftIn  (txLeft),
    .txRightIn (txRight),
    .serOut    (serOut),
    .rxLeftOut (rxLeft),
    .rxRightOut(rxRight),
    .rxValid   (rxValid)
  );
endmodule

// File: rtl/asp_checker.sv
module asp_checker
  import asp_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                pwrDn,
  input strb_t               strb,
  input logic                serOut,
  input logic [SAMPLE_W-1:0] rxLeft,
  input logic [SAMPLE_W-1:0] rxRight,
  input logic                rxValid
);
  a_r6_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(serOut) |-> ($past(strb.fallEdge) || $past(pwrDn)));

  a_r7_powerdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwrDn) |-> (!serOut && !rxValid));

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  a_r8_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rxValid |-> ($stable(rxLeft) && $stable(rxRight)));

  a_r10_pos_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.halfStart && !pwrDn) |=> (strb.pos == '0));
endmodule

bind audio_serial_port asp_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pwrDn  (pwrDn),
  .strb   (strb),
  .serOut (serOut),
  .rxLeft (rxLeft),
  .rxRight(rxRight),
  .rxValid(rxValid)
);

// File: tb/audio_serial_port_bench.sv
module audio_serial_port_bench;
  localparam int HB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrDn = 1'b0;
  logic [1:0] fmtSel = 2'd0;
  logic bitClk = 1'b1, wordClk = 1'b0, serIn = 1'b0;
  logic serOut, rxValid;
  logic [23:0] txLeft = '0, txRight = '0, rxLeft, rxRight;

  int checks = 0, fails = 0, vCount = 0;
  logic [23:0] vL, vR;

  always #2.5 clk = ~clk;

  audio_serial_port u_audio_serial_port (
    .clk(clk), .rst_n(rst_n), .pwrDn(pwrDn), .fmtSel(fmtSel),
    .bitClk(bitClk), .wordClk(wordClk), .serIn(serIn), .serOut(serOut),
    .txLeft(txLeft), .txRight(txRight), .rxLeft(rxLeft), .rxRight(rxRight),
    .rxValid(rxValid)
  );

  always @(negedge clk) if (rxValid) begin
    vCount++;
    vL = rxLeft;
    vR = rxRight;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic logic txExp(input int fmt, input logic [23:0] w, input int p);
    int s = (fmt == 1) ? 1 : 0;
    if (p >= s && p < s + 24) return w[23 - (p - s)];
    return 1'b0;
  endfunction

  function automatic logic rxDrv(input int fmt, input logic [23:0] w, input int p, input logic fill);
    int s = (fmt == 1) ? 1 : (fmt == 2) ? 8 : 0;
    if (p >= s && p < s + 24) return w[23 - (p - s)];
    return fill;
  endfunction

  task automatic slot(input logic w, input logic d, output logic soA, output logic soB);
    @(negedge clk);
    bitClk = 1'b0; wordClk = w; serIn = d;
    repeat (HB) @(negedge clk);
    soA = serOut;
    bitClk = 1'b1;
    repeat (HB - 1) @(negedge clk);
    soB = serOut;
  endtask

  task automatic preamble(input int fmt);
    logic a, b;
    logic lvl = (fmt == 1) ? 1'b0 : 1'b1;
    fmtSel = 2'(fmt);
    for (int i = 0; i < 3; i++) slot(~lvl, 1'b0, a, b);
  endtask

  task automatic runFrame(input string tagTx, input string tagRx, input int fmt,
                          input int halfLen, input logic [23:0] l, input logic [23:0] r,
                          input logic [23:0] inL, input logic [23:0] inR,
                          input bit midChange, input logic fill, input bit pd);
    logic [31:0] act[2], exp[2];
    int edgeErr = 0;
    logic lvl = (fmt == 1) ? 1'b0 : 1'b1;
    fmtSel = 2'(fmt);
    txLeft = l; txRight = r;
    vCount = 0;
    act[0] = '0; act[1] = '0; exp[0] = '0; exp[1] = '0;
    for (int b = 0; b < 2 * halfLen; b++) begin
      int h = b / halfLen;
      int p = b % halfLen;
      logic a, bb;
      if (midChange && b == 5) begin txLeft = ~l; txRight = ~r; end
      slot(h == 0 ? lvl : ~lvl, rxDrv(fmt, h == 0 ? inL : inR, p, fill), a, bb);
      act[h][31 - p] = a;
      exp[h][31 - p] = pd ? 1'b0 : txExp(fmt, h == 0 ? l : r, p);
      if (a !== bb) edgeErr++;
    end
    check(act[0] === exp[0], tagTx, "left tx slots", act[0], exp[0]);
    check(act[1] === exp[1], tagTx, "right tx slots", act[1], exp[1]);
    check(edgeErr == 0, "R6", "output change at rising edge", edgeErr, 0);
    if (pd) begin
      check(vCount == 0, "R7", "valid pulses in power-down", vCount, 0);
    end else begin
      check(vCount == 1, "R8", "valid pulse count", vCount, 1);
      check(vL === inL, tagRx, "received left", {8'h0, vL}, {8'h0, inL});
      check(vR === inR, tagRx, "received right", {8'h0, vR}, {8'h0, inR});
    end
  endtask

  task automatic testReset();
    check(serOut === 1'b0, "R7", "reset serOut", serOut, 0);
    check(rxValid === 1'b0, "R8", "reset rxValid", rxValid, 0);
  endtask

  // R1 R2 R4: left-justified, ones after LSB must be ignored
  task automatic testLj();
    preamble(0);
    runFrame("R1", "R4", 0, 32, 24'h800001, 24'h7FFFFE, 24'hA5C3F0, 24'h1234EF, 0, 1'b1, 0);
    runFrame("R2", "R4", 0, 32, 24'h0F0F0F, 24'hF0F0F1, 24'h800000, 24'h7FFFFF, 0, 1'b0, 0);
  endtask

  // R3 R2: I2S, left on low word clock, one-slot delay
  task automatic testI2s();
    preamble(1);
    runFrame("R3", "R3", 1, 32, 24'hC00003, 24'h3FFFFC, 24'h96A55A, 24'h000001, 0, 1'b1, 0);
  endtask

  // R5 R1: mixed mode, ones in slots 0..7 ignored on receive
  task automatic testMix();
    preamble(2);
    runFrame("R1", "R5", 2, 32, 24'hDEADBE, 24'h112233, 24'h5AA5C3, 24'hFEDCBA, 0, 1'b1, 0);
  endtask

  // R10: 48 bit clocks per frame
  task automatic testShort();
    preamble(0);
    runFrame("R10", "R10", 0, 24, 24'h813579, 24'h2468AC, 24'hBEEF01, 24'h00FACE, 0, 1'b0, 0);
  endtask

  // R9: port changes mid-frame do not corrupt the shift
  task automatic testLatch();
    preamble(0);
    runFrame("R9", "R4", 0, 32, 24'h6C6C6C, 24'h939393, 24'h010203, 24'h040506, 1, 1'b0, 0);
  endtask

  // R7: power-down holds output low, then recovery
  task automatic testPowerDown();
    pwrDn = 1'b1;
    preamble(0);
    runFrame("R7", "R7", 0, 32, 24'hFFFFFF, 24'hFFFFFF, 24'h777777, 24'h888888, 0, 1'b0, 1);
    @(negedge clk);
    pwrDn = 1'b0;
    preamble(0);
    runFrame("R7", "R7", 0, 32, 24'hABCDEF, 24'h123456, 24'h654321, 24'hFEDCBA, 0, 1'b0, 0);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testLj();
    testI2s();
    testMix();
    testShort();
    testLatch();
    testPowerDown();
    summary();
    $finish;
  end
endmodule